// File: doc/BRIEF.md
# Width-Selectable Byte FIFO with Watermarks

This block is a 256-byte first-in first-out buffer that sits between a register bus and a serial shift engine. It serves either the transmit side (software writes the data port, the engine pops) or the receive side (the engine pushes, software reads the data port). One shared byte store is carved into entries of 1, 2 or 4 bytes, chosen at run time. Capacity is therefore 256, 128 or 64 entries.

Software prepares a transfer in a fixed order. It flushes and starts the FIFO through the operation register, then sets the entry width, a threshold and three watermark levels. After that it moves data. The block reports full, empty, threshold-reached and one hit flag per watermark. An interrupt unit picks these up, and so does whoever refills or drains the FIFO.

The engine reaches the FIFO through a bare push/pop port and has priority over the bus data port.

Top module: `flex_fifo`

## Requirements
- R1: After `rst` the FIFO is stopped and empty. `flag_empty`=1, `flag_full`=0, `flag_thd`=1 and all `wm_hit` bits are 1, because every level register and the threshold reset to zero. A status read returns 0x200.
- R2: Operation register, address 1:
  - A write with bit 0 set flushes all contents.
  - Bit 1 of any write to it sets the running state.
  - While stopped, pushes and pops have no effect and the contents are kept.
- R3: Control register, address 0: bits 1:0 select the entry width, with 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits.
  - A push stores the low bits of its data word.
  - A pop returns the oldest entry, zero-extended to 32 bits.
- R4: Capacity is 256 bytes. `flag_full` is high exactly when 256, 128 or 64 entries are held for width 8, 16 or 32. A push while full is ignored.
- R5: A pop while empty is ignored and returns 0.
- R6: Status register, address 3:
  - Bits 7:0 hold the low 8 bits of the entry count.
  - Bit 8 is full and bit 9 is empty. The upper bits are zero.
  - The value reflects the state before the reading cycle's clock edge.
- R7: Control bits 9:2 hold an 8-bit threshold. `flag_thd` is high when the entry count is at least the threshold.
- R8: Watermark register, address 2, holds three 6-bit levels at bits 5:0, 15:10 and 25:20. `wm_hit[k]` is high when the stored bytes divided by 4 is at least level k.
- R9: Engine priority on the data port, address 4:
  - If an engine push and a bus data write fall in the same cycle, only the engine word is pushed.
  - If an engine pop and a bus data read fall in the same cycle, the engine gets the entry and `bus_rdata` is 0.
- R10: Read latency and idle values:
  - `bus_rdata` and `eng_rdata` are valid in the cycle after the request and are 0 after a cycle with no read or no accepted pop.
  - The flags are registers that show the state after each edge.
- R11: The control and watermark registers read back their fields at the positions above. The operation register reads the running state in bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, one cycle after `bus_rd` |
| eng_push | input | 1 | Engine push request |
| eng_wdata | input | 32 | Engine push data |
| eng_pop | input | 1 | Engine pop request |
| eng_rdata | output | 32 | Engine pop data, one cycle after `eng_pop` |
| flag_full | output | 1 | FIFO full |
| flag_empty | output | 1 | FIFO empty |
| flag_thd | output | 1 | Entry count at or above threshold |
| wm_hit | output | 3 | Per-watermark comparator results |

## Verification
Each entry width is filled to capacity with a counting pattern and then drained. This separates correct byte-lane placement, pointer wrap and masking from a design that only handles one width.

Pushes issued while full, pops issued while empty, and traffic issued while stopped are aimed at the guard conditions. Resuming without a flush shows that stopping kept the contents.

A cycle that hits both the bus data port and the engine port isolates the priority rule. A long random mix of pushes, pops, status reads and flush-restarts compares every flag and read value against a queue model. This exposes off-by-one errors in the threshold and watermark comparisons.

// File: rtl/flexfifo_pkg.sv
package flexfifo_pkg;

  typedef enum logic [1:0] {
    EW_BYTE     = 2'd0,
    EW_HALF     = 2'd1,
    EW_WORD     = 2'd2,
    EW_WORD_ALT = 2'd3
  } ent_width_e;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_OP   = 3'd1;
  localparam logic [2:0] RA_MARK = 3'd2;
  localparam logic [2:0] RA_STAT = 3'd3;
  localparam logic [2:0] RA_DATA = 3'd4;

  // log2 of bytes per entry for a width code
  function automatic logic [1:0] width_shift(input logic [1:0] code);
    case (ent_width_e'(code))
      EW_BYTE: width_shift = 2'd0;
      EW_HALF: width_shift = 2'd1;
      default: width_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/flexfifo_regs.sv
module flexfifo_regs import flexfifo_pkg::*; #(
  parameter int DATA_W    = 32,
  parameter int THD_W     = 8,
  parameter int WM_W      = 6,
  parameter int NUM_WM    = 3,
  parameter int WM_STRIDE = 10,
  parameter int ADDR_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [1:0]               cur_shift,
  output logic [1:0]               nxt_shift,
  output logic [THD_W-1:0]         nxt_thd,
  output logic [NUM_WM*WM_W-1:0]   nxt_marks,
  output logic                     running,
  output logic                     flush,
  output logic [DATA_W-1:0]        ctrl_word,
  output logic [DATA_W-1:0]        mark_word,
  output logic [DATA_W-1:0]        op_word
);

  logic                   wr_ctrl, wr_op, wr_mark;
  logic [1:0]             wcode_q, wcode_nxt;
  logic [THD_W-1:0]       thd_q;
  logic [NUM_WM*WM_W-1:0] marks_q;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(RA_CTRL));
  assign wr_op   = bus_wr && (bus_addr == ADDR_W'(RA_OP));
  assign wr_mark = bus_wr && (bus_addr == ADDR_W'(RA_MARK));

  assign wcode_nxt = wr_ctrl ? bus_wdata[1:0] : wcode_q;
  assign nxt_thd   = wr_ctrl ? bus_wdata[2 +: THD_W] : thd_q;
  assign cur_shift = width_shift(wcode_q);
  assign nxt_shift = width_shift(wcode_nxt);
  assign flush     = wr_op && bus_wdata[0];

  for (genvar k = 0; k < NUM_WM; k++) begin : g_mark
    assign nxt_marks[k*WM_W +: WM_W] =
      wr_mark ? bus_wdata[k*WM_STRIDE +: WM_W] : marks_q[k*WM_W +: WM_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcode_q <= '0;
      thd_q   <= '0;
      marks_q <= '0;
      running <= 1'b0;
    end else begin
      wcode_q <= wcode_nxt;
      thd_q   <= nxt_thd;
      marks_q <= nxt_marks;
      if (wr_op) running <= bus_wdata[1];
    end
  end

  assign ctrl_word = DATA_W'({thd_q, wcode_q});
  assign op_word   = DATA_W'({running, 1'b0});

  always_comb begin
    mark_word = '0;
    for (int k = 0; k < NUM_WM; k++)
      mark_word[k*WM_STRIDE +: WM_W] = marks_q[k*WM_W +: WM_W];
  end

endmodule

// File: rtl/flexfifo_ctl.sv
module flexfifo_ctl #(
  parameter int DEPTH_BYTES = 256,
  parameter int THD_W       = 8,
  parameter int WM_W        = 6,
  parameter int NUM_WM      = 3,
  localparam int PTR_W      = $clog2(DEPTH_BYTES),
  localparam int CNT_W      = PTR_W + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   running,
  input  logic [1:0]             cur_shift,
  input  logic [1:0]             nxt_shift,
  input  logic [THD_W-1:0]       nxt_thd,
  input  logic [NUM_WM*WM_W-1:0] nxt_marks,
  input  logic                   push_req,
  input  logic                   pop_req,
  output logic                   push_ok,
  output logic                   pop_ok,
  output logic [PTR_W-1:0]       wr_ptr,
  output logic [PTR_W-1:0]       rd_ptr,
  output logic [CNT_W-1:0]       entries,
  output logic                   full_q,
  output logic                   empty_q,
  output logic                   thd_q,
  output logic [NUM_WM-1:0]      wm_q
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, step, ent_nxt, units_nxt;

  assign step    = CNT_W'(1) << cur_shift;
  assign push_ok = push_req && running && !flush && ((CAP - cnt_q) >= step);
  assign pop_ok  = pop_req && running && !flush && (cnt_q >= step);

  always_comb begin
    cnt_nxt = cnt_q;
    if (flush) begin
      cnt_nxt = '0;
    end else begin
      if (push_ok) cnt_nxt = cnt_nxt + step;
      if (pop_ok)  cnt_nxt = cnt_nxt - step;
    end
  end

  assign entries   = cnt_q >> cur_shift;
  assign ent_nxt   = cnt_nxt >> nxt_shift;
  assign units_nxt = cnt_nxt >> 2;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok) wr_ptr <= wr_ptr + PTR_W'(step);
        if (pop_ok)  rd_ptr <= rd_ptr + PTR_W'(step);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      thd_q   <= 1'b1;
    end else begin
      full_q  <= (cnt_nxt == CAP);
      empty_q <= (cnt_nxt == '0);
      thd_q   <= (ent_nxt >= CNT_W'(nxt_thd));
    end
  end

  for (genvar k = 0; k < NUM_WM; k++) begin : g_wm
    always_ff @(posedge clk) begin
      if (rst) wm_q[k] <= 1'b1;
      else     wm_q[k] <= (units_nxt >= CNT_W'(nxt_marks[k*WM_W +: WM_W]));
    end
  end

endmodule

// File: rtl/flexfifo_store.sv
module flexfifo_store #(
  parameter int DEPTH_BYTES = 256,
  parameter int DATA_W      = 32,
  localparam int LANES      = DATA_W / 8,
  localparam int LANE_W     = $clog2(LANES),
  localparam int ROWS       = DEPTH_BYTES / LANES,
  localparam int PTR_W      = $clog2(DEPTH_BYTES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [1:0]        wr_shift,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [1:0]        rd_shift,
  output logic [DATA_W-1:0] rd_entry
);

  logic [PTR_W-LANE_W-1:0] wr_row, rd_row;
  logic [LANE_W-1:0]       wr_lane, base, rd_lane_q;
  logic [LANE_W:0]         span;
  logic [1:0]              rd_shift_q;
  logic [DATA_W-1:0]       row_word, shifted;

  assign wr_row  = wr_ptr[PTR_W-1:LANE_W];
  assign rd_row  = rd_ptr[PTR_W-1:LANE_W];
  assign wr_lane = wr_ptr[LANE_W-1:0];
  assign span    = (LANE_W+1)'(1) << wr_shift;
  assign base    = wr_lane & ~LANE_W'(span - 1'b1);

  // one byte-wide RAM per lane, write-enabled by entry position
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0]        mem [ROWS];
    logic [7:0]        q;
    logic [LANE_W-1:0] off;
    logic              en;
    logic [7:0]        din;

    assign off = LANE_W'(i) - base;
    assign en  = we && (LANE_W'(i) >= base) && ((LANE_W+1)'(off) < span);
    assign din = wdata[{off, 3'b000} +: 8];

    always_ff @(posedge clk) begin
      if (en) mem[wr_row] <= din;
      if (re) q <= mem[rd_row];
    end

    assign row_word[8*i +: 8] = q;
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rd_lane_q  <= rd_ptr[LANE_W-1:0];
      rd_shift_q <= rd_shift;
    end
  end

  always_comb begin
    shifted = row_word >> {rd_lane_q, 3'b000};
    case (rd_shift_q)
      2'd0:    rd_entry = DATA_W'(shifted[7:0]);
      2'd1:    rd_entry = DATA_W'(shifted[15:0]);
      default: rd_entry = shifted;
    endcase
  end

endmodule

// File: rtl/flex_fifo.sv
module flex_fifo import flexfifo_pkg::*; #(
  parameter int DEPTH_BYTES = 256,
  parameter int DATA_W      = 32,
  parameter int THD_W       = 8,
  parameter int WM_W        = 6,
  parameter int NUM_WM      = 3,
  parameter int WM_STRIDE   = 10,
  parameter int ADDR_W      = 3,
  parameter int LVL_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_push,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic              eng_pop,
  output logic [DATA_W-1:0] eng_rdata,
  output logic              flag_full,
  output logic              flag_empty,
  output logic              flag_thd,
  output logic [NUM_WM-1:0] wm_hit
);

  localparam int PTR_W = $clog2(DEPTH_BYTES);
  localparam int CNT_W = PTR_W + 1;

  logic [1:0]             cur_shift, nxt_shift;
  logic [THD_W-1:0]       nxt_thd;
  logic [NUM_WM*WM_W-1:0] nxt_marks;
  logic                   cfg_running, flush;
  logic [DATA_W-1:0]      ctrl_word, mark_word, op_word, stat_word, reg_val, reg_q;
  logic                   data_wr, data_rd, push_ok, pop_ok;
  logic [DATA_W-1:0]      push_data, rd_entry;
  logic [PTR_W-1:0]       wr_ptr, rd_ptr;
  logic [CNT_W-1:0]       entries;
  logic                   bus_pop_q, eng_pop_q;

  assign data_wr   = bus_wr && (bus_addr == ADDR_W'(RA_DATA));
  assign data_rd   = bus_rd && (bus_addr == ADDR_W'(RA_DATA));
  assign push_data = eng_push ? eng_wdata : bus_wdata;

  flexfifo_regs #(
    .DATA_W(DATA_W), .THD_W(THD_W), .WM_W(WM_W), .NUM_WM(NUM_WM),
    .WM_STRIDE(WM_STRIDE), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cur_shift(cur_shift), .nxt_shift(nxt_shift), .nxt_thd(nxt_thd), .nxt_marks(nxt_marks),
    .running(cfg_running), .flush(flush),
    .ctrl_word(ctrl_word), .mark_word(mark_word), .op_word(op_word)
  );

  flexfifo_ctl #(
    .DEPTH_BYTES(DEPTH_BYTES), .THD_W(THD_W), .WM_W(WM_W), .NUM_WM(NUM_WM)
  ) u_ctl (
    .clk(clk), .rst(rst), .flush(flush), .running(cfg_running),
    .cur_shift(cur_shift), .nxt_shift(nxt_shift), .nxt_thd(nxt_thd), .nxt_marks(nxt_marks),
    .push_req(eng_push || data_wr), .pop_req(eng_pop || data_rd),
    .push_ok(push_ok), .pop_ok(pop_ok), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .entries(entries), .full_q(flag_full), .empty_q(flag_empty),
    .thd_q(flag_thd), .wm_q(wm_hit)
  );

  flexfifo_store #(
    .DEPTH_BYTES(DEPTH_BYTES), .DATA_W(DATA_W)
  ) u_store (
    .clk(clk), .we(push_ok), .wr_ptr(wr_ptr), .wr_shift(cur_shift), .wdata(push_data),
    .re(pop_ok), .rd_ptr(rd_ptr), .rd_shift(cur_shift), .rd_entry(rd_entry)
  );

  always_comb begin
    stat_word = '0;
    stat_word[LVL_W-1:0] = entries[LVL_W-1:0];
    stat_word[LVL_W]     = flag_full;
    stat_word[LVL_W+1]   = flag_empty;
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(RA_CTRL): reg_val = ctrl_word;
      ADDR_W'(RA_OP):   reg_val = op_word;
      ADDR_W'(RA_MARK): reg_val = mark_word;
      ADDR_W'(RA_STAT): reg_val = stat_word;
      default:          reg_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      bus_pop_q <= 1'b0;
      eng_pop_q <= 1'b0;
    end else begin
      reg_q     <= (bus_rd && !data_rd) ? reg_val : '0;
      bus_pop_q <= pop_ok && data_rd && !eng_pop;
      eng_pop_q <= pop_ok && eng_pop;
    end
  end

  assign bus_rdata = bus_pop_q ? rd_entry : reg_q;
  assign eng_rdata = eng_pop_q ? rd_entry : '0;

endmodule

// File: rtl/flexfifo_chk.sv
module flexfifo_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              eng_pop,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] eng_rdata,
  input logic              flag_full,
  input logic              flag_empty,
  input logic              running
);

  // R4: full and empty never together
  a_r4_full_empty_excl: assert property (@(posedge clk) disable iff (rst)
    !(flag_full && flag_empty));

  // R5: a pop on an empty FIFO returns zero
  a_r5_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
    (flag_empty && eng_pop) |=> (eng_rdata == '0));

  // R10: no read means zero read data next cycle
  a_r10_idle_rdata_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  // R9: engine pop shadows a same-cycle bus data read
  a_r9_engine_pop_wins: assert property (@(posedge clk) disable iff (rst)
    (eng_pop && bus_rd && bus_addr == ADDR_W'(4)) |=> (bus_rdata == '0));

  // R2: stopped FIFO keeps its fill state unless the operation register is written
  a_r2_stopped_hold: assert property (@(posedge clk) disable iff (rst)
    (!running && !(bus_wr && bus_addr == ADDR_W'(1)))
      |=> ($stable(flag_full) && $stable(flag_empty)));

endmodule

bind flex_fifo flexfifo_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .eng_pop(eng_pop), .bus_rdata(bus_rdata), .eng_rdata(eng_rdata),
  .flag_full(flag_full), .flag_empty(flag_empty), .running(cfg_running)
);

// File: tb/flex_fifo_bench.sv
`timescale 1ns/1ps
module flex_fifo_bench;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0, eng_push = 0, eng_pop = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, eng_wdata = 0;
  logic [31:0] bus_rdata, eng_rdata;
  logic        flag_full, flag_empty, flag_thd;
  logic [2:0]  wm_hit;

  always #2 clk = ~clk;

  flex_fifo u_flex_fifo (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_push(eng_push),
    .eng_wdata(eng_wdata), .eng_pop(eng_pop), .eng_rdata(eng_rdata),
    .flag_full(flag_full), .flag_empty(flag_empty), .flag_thd(flag_thd), .wm_hit(wm_hit)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // behavioural model
  int unsigned q[$];
  int wcode = 0, thd = 0, run = 0;
  int marks[3] = '{0, 0, 0};

  function automatic int wbytes();
    return (wcode == 0) ? 1 : (wcode == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] wmask();
    return (wcode == 0) ? 32'hFF : (wcode == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic chk_flags();
    int b;
    logic [2:0] ew;
    b = q.size() * wbytes();
    for (int k = 0; k < 3; k++) ew[k] = ((b / 4) >= marks[k]);
    chk(32'(flag_full),  32'(b == DEPTH),     "R4 flag_full");
    chk(32'(flag_empty), 32'(q.size() == 0),  "R5 flag_empty");
    chk(32'(flag_thd),   32'(q.size() >= thd), "R7 flag_thd");
    chk(32'(wm_hit),     32'(ew),             "R8 wm_hit");
  endtask

  task automatic cyc(input logic bw, input logic br, input logic [2:0] a, input logic [31:0] wd,
                     input logic ep, input logic [31:0] ewd, input logic epp, input string tag);
    int wb, bytes;
    bit flush, preq, prq, push_ok, pop_ok;
    logic [31:0] head, pdata, exp_bus, exp_eng;
    bus_wr = bw; bus_rd = br; bus_addr = a; bus_wdata = wd;
    eng_push = ep; eng_wdata = ewd; eng_pop = epp;
    wb      = wbytes();
    bytes   = q.size() * wb;
    flush   = bw && a == 3'd1 && wd[0];
    preq    = ep || (bw && a == 3'd4);
    prq     = epp || (br && a == 3'd4);
    push_ok = (run != 0) && !flush && preq && (bytes + wb <= DEPTH);
    pop_ok  = (run != 0) && !flush && prq && q.size() > 0;
    head    = (q.size() > 0) ? q[0] : 32'd0;
    pdata   = ep ? ewd : wd;
    exp_eng = (epp && pop_ok) ? head : 32'd0;
    exp_bus = 32'd0;
    if (br) begin
      case (a)
        3'd0: exp_bus = 32'((thd << 2) | wcode);
        3'd1: exp_bus = 32'(run << 1);
        3'd2: exp_bus = 32'((marks[2] << 20) | (marks[1] << 10) | marks[0]);
        3'd3: exp_bus = {22'd0, q.size() == 0, bytes == DEPTH, 8'(q.size())};
        3'd4: exp_bus = (pop_ok && !epp) ? head : 32'd0;
        default: exp_bus = 32'd0;
      endcase
    end
    if (pop_ok) void'(q.pop_front());
    if (push_ok) q.push_back(pdata & wmask());
    if (flush) q.delete();
    if (bw && a == 3'd0) begin wcode = int'(wd[1:0]); thd = int'(wd[9:2]); end
    if (bw && a == 3'd1) run = int'(wd[1]);
    if (bw && a == 3'd2) begin
      marks[0] = int'(wd[5:0]); marks[1] = int'(wd[15:10]); marks[2] = int'(wd[25:20]);
    end
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; eng_push = 0; eng_pop = 0;
    chk(bus_rdata, exp_bus, {tag, " bus_rdata"});
    chk(eng_rdata, exp_eng, {tag, " eng_rdata"});
    chk_flags();
  endtask

  task automatic bwr(input logic [2:0] a, input logic [31:0] d, input string tag);
    cyc(1, 0, a, d, 0, 0, 0, tag);
  endtask
  task automatic brd(input logic [2:0] a, input string tag);
    cyc(0, 1, a, 0, 0, 0, 0, tag);
  endtask
  task automatic epush(input logic [31:0] d, input string tag);
    cyc(0, 0, 0, 0, 1, d, 0, tag);
  endtask
  task automatic epopt(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(32'(flag_empty), 32'd1, "R1 reset empty");
    chk(32'(flag_full),  32'd0, "R1 reset full");
    chk(32'(flag_thd),   32'd1, "R1 reset thd");
    chk(32'(wm_hit),     32'd7, "R1 reset wm");
    brd(3'd3, "R1 status");
    brd(3'd1, "R11 op");

    // R2: stopped FIFO ignores traffic
    epush(32'h55, "R2 stopped push");
    bwr(3'd4, 32'h1, "R2 stopped bus push");
    brd(3'd3, "R2 status stopped");

    // R3: byte mode basic order
    bwr(3'd1, 32'd3, "R2 flush start");
    brd(3'd1, "R11 op running");
    bwr(3'd4, 32'h1234_56A1, "R3 bus push");
    epush(32'hFFFF_FFB2, "R3 eng push");
    brd(3'd4, "R3 bus pop");
    epopt("R3 eng pop");

    // R4: fill bytes to capacity
    for (int i = 0; i < DEPTH; i++) epush(32'(i + 32'h300), "R4 fill byte");
    brd(3'd3, "R6 status full");
    epush(32'h77, "R4 push when full");
    for (int i = 0; i < DEPTH; i++) begin
      if (i % 2 == 0) brd(3'd4, "R3 drain bus");
      else epopt("R3 drain eng");
    end
    epopt("R5 pop empty eng");
    brd(3'd4, "R5 pop empty bus");

    // R7, R8, R11: threshold and watermarks
    bwr(3'd0, 32'(5 << 2), "R11 ctrl write");
    bwr(3'd2, 32'((62 << 20) | (32 << 10) | 2), "R8 marks write");
    brd(3'd0, "R11 ctrl read");
    brd(3'd2, "R11 marks read");
    for (int i = 0; i < 10; i++) epush(32'(i), "R7 thd ramp");
    brd(3'd3, "R6 status ten");

    // R3, R4: 16-bit width
    bwr(3'd1, 32'd3, "R2 flush");
    bwr(3'd0, 32'((100 << 2) | 1), "R3 half width");
    for (int i = 0; i < 130; i++) epush(32'hABCD_0000 + 32'(i * 257), "R4 fill half");
    brd(3'd3, "R6 status half full");
    for (int i = 0; i < 128; i++) begin
      if (i % 3 == 0) brd(3'd4, "R3 half bus pop");
      else epopt("R3 half eng pop");
    end

    // R3, R4: 32-bit width
    bwr(3'd1, 32'd3, "R2 flush");
    bwr(3'd0, 32'((64 << 2) | 2), "R3 word width");
    for (int i = 0; i < 65; i++) bwr(3'd4, 32'h8000_0001 * 32'(i + 1), "R4 fill word");
    brd(3'd3, "R6 status word full");

    // R2: stop keeps contents, restart resumes
    epopt("R3 word pop");
    bwr(3'd1, 32'd0, "R2 stop");
    epopt("R2 stopped pop");
    epush(32'h1, "R2 stopped push");
    brd(3'd3, "R2 status stopped");
    bwr(3'd1, 32'd2, "R2 restart");
    for (int i = 0; i < 63; i++) epopt("R3 word drain");

    // R9: engine priority
    cyc(1, 0, 3'd4, 32'hAAAA_AAAA, 1, 32'hBBBB_BBBB, 0, "R9 push clash");
    cyc(0, 1, 3'd4, 0, 0, 0, 1, "R9 pop clash");
    brd(3'd3, "R9 status after clash");

    // R3: width code 3 acts as 32-bit
    bwr(3'd1, 32'd3, "R2 flush");
    bwr(3'd0, 32'd3, "R3 width code 3");
    epush(32'hDEAD_BEEF, "R3 alt push");
    brd(3'd4, "R3 alt pop");

    // random mix across widths
    for (int round = 0; round < 3; round++) begin
      bwr(3'd1, 32'd3, "R2 flush");
      bwr(3'd0, 32'(((round * 20 + 3) << 2) | round), "R3 width set");
      bwr(3'd2, 32'(((round * 9 + 40) << 20) | ((round * 7 + 16) << 10) | (round + 1)),
          "R8 marks set");
      for (int i = 0; i < 1500; i++) begin
        int r;
        r = int'($urandom_range(0, 99));
        if (r < 35)      epush($urandom, "R10 rnd eng push");
        else if (r < 50) bwr(3'd4, $urandom, "R10 rnd bus push");
        else if (r < 70) epopt("R10 rnd eng pop");
        else if (r < 82) brd(3'd4, "R10 rnd bus pop");
        else if (r < 90) brd(3'd3, "R6 rnd status");
        else if (r < 96) cyc(1'($urandom), 1'($urandom), 3'd4, $urandom, 1'($urandom), $urandom,
                             1'($urandom), "R9 rnd clash");
        else             cyc(0, 0, 0, 0, 0, 0, 0, "R10 rnd idle");
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule